// File: doc/BRIEF.md
# Write Burst Interrupt-by-Read Mask Controller

This block sits on the controller side of a double-data-rate memory write path. The controller may issue a read while one of its own write bursts is still being transferred. The block tracks each write burst as a run of data slots, one clock per slot and two data beats per slot. When a read arrives during such a run, the block decides whether the read may cut the burst short. If it may, the block raises the per-byte write mask for the slot in progress and for the slot that follows. It also withdraws the data and strobe output enable in time for the bus to turn around before read data returns.

A read that comes one clock after its write, a read issued in the same cycle as a write, and any read that overlaps a burst while the interrupt feature is switched off are all flagged as rejected. In each of these cases the write finishes exactly as if the read had not been issued. The data path also supplies a per-beat valid, and a beat without valid data is masked as well.

Top module: `wrint_mask_ctrl`

## Requirements
- R1: A write command with burst code k (field `bl_code`: 1 = two beats, 2 = four beats, 3 = eight beats) drives `oe_o` high for 2^(k-1) consecutive cycles, starting in the cycle after the command. Code 0 starts no burst.
- R2: A read issued in the first data slot of a burst (one clock after the write command) raises `rej_o` in that same cycle. The burst then completes in full and unmasked.
- R3: With `intr_en` low, a read issued while `oe_o` is high is rejected in that cycle and leaves the burst unchanged. `rej_o` is never high without `rd_cmd`.
- R4: An accepted interrupting read (issued while `oe_o` is high, and not rejected) sets every `dm_o` bit in the read's own cycle and in the next cycle, whenever `oe_o` is high in that next cycle.
- R5: Data slots that come before the interrupting read's cycle keep `dm_o` at zero when the data is valid, so they are written normally.
- R6: After an accepted interrupt, `oe_o` is low from cycle read+CAS_LAT-1 onward (read+2 at the default latency of 3), unless a new write starts. Slots of the burst that are still pending after that point are dropped.
- R7: A read issued while no data slot is active is not rejected and does not change `oe_o` or `dm_o`.
- R8: In an active slot, a low `wdat_vld[b]` sets the mask of beat b in both lanes. Bit `dm_o[b*LANES+l]` is beat b (0 = first beat of the clock), lane l (0 = lower byte).
- R9: `dm_o` is zero whenever `oe_o` is low, and all lanes of a beat always carry the same mask.
- R10: A read issued in the same cycle as a write is rejected. The write starts normally.
- R11: While `rst_n` is low, `oe_o`, `dm_o` and `rej_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock; commands are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| intr_en | input | 1 | Allows a read to interrupt a write burst |
| bl_code | input | BL_CODE_W (2) | Burst length code for the write command |
| wr_cmd | input | 1 | Write command strobe |
| rd_cmd | input | 1 | Read command strobe |
| wdat_vld | input | BEATS (2) | Per-beat write data valid from the data path for the current slot |
| dm_o | output | BEATS*LANES (4) | Per-beat, per-lane write mask for the current slot |
| oe_o | output | 1 | Data and strobe output enable (high while a data slot is driven) |
| rej_o | output | 1 | The read in this cycle is rejected |

## Verification
The bench builds the block with its defaults: two lanes, two beats per clock, a two-bit burst code and a read latency of 3. With these values a single hold slot follows an interrupt, and the longest burst has four slots. Reads can therefore land on the first slot, on a middle slot with pending slots cut, on the last slot, and just past the end of a burst. Four-slot and two-slot bursts are both driven, so truncation to the hold slot and natural completion at the read's cycle are reached with the same latency setting.

// File: rtl/wrint_pkg.sv
`timescale 1ns/1ps
package wrint_pkg;

   // Decision taken on a read command in the current cycle.
   typedef struct packed {
      logic accept;   // read cuts the active write burst
      logic reject;   // read refused; write left untouched
   } rd_verdict_t;

   // Number of one-clock data slots for a burst code (two beats per slot).
   function automatic int unsigned slots_for_code(input int unsigned code);
      return (code == 0) ? 0 : (32'd1 << (code - 1));
   endfunction

endpackage

// File: rtl/wrint_burst_track.sv
`timescale 1ns/1ps
module wrint_burst_track
   import wrint_pkg::*;
#(
   parameter int BL_CODE_W = 2,
   parameter int SLOT_W    = 3,
   parameter int HOLD      = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 cut,
   input  logic [BL_CODE_W-1:0] bl_code,
   output logic                 active,
   output logic                 first,
   output logic                 masked
);

   logic [SLOT_W-1:0] rem_q;
   logic [SLOT_W-1:0] load_val;
   logic [SLOT_W-1:0] rem_after_cut;
   logic              first_q;
   logic              mask_q;

   assign load_val = SLOT_W'(slots_for_code(int'(bl_code)));

   generate
      if (HOLD == 0) begin : g_drop_all
         // Read latency leaves no slot to drive after the read.
         assign rem_after_cut = '0;
      end else begin : g_keep_hold
         localparam logic [SLOT_W-1:0] HOLD_V = SLOT_W'(HOLD);
         logic [SLOT_W-1:0] dec;
         assign dec           = rem_q - SLOT_W'(1);
         assign rem_after_cut = (dec < HOLD_V) ? dec : HOLD_V;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q   <= '0;
         first_q <= 1'b0;
         mask_q  <= 1'b0;
      end else if (start) begin
         rem_q   <= load_val;
         first_q <= (load_val != '0);
         mask_q  <= 1'b0;
      end else if (cut) begin
         rem_q   <= rem_after_cut;
         first_q <= 1'b0;
         mask_q  <= (rem_after_cut != '0);
      end else begin
         rem_q   <= (rem_q != '0) ? rem_q - SLOT_W'(1) : '0;
         first_q <= 1'b0;
         mask_q  <= mask_q && (rem_q > SLOT_W'(1));
      end
   end

   assign active = (rem_q != '0);
   assign first  = first_q;
   assign masked = mask_q;

endmodule

// File: rtl/wrint_rd_arbiter.sv
`timescale 1ns/1ps
module wrint_rd_arbiter
   import wrint_pkg::*;
(
   input  logic        rd_cmd,
   input  logic        wr_cmd,
   input  logic        active,
   input  logic        first,
   input  logic        intr_en,
   output rd_verdict_t verdict
);

   logic clash;

   // A read clashes with a write issued alongside it, with the first slot
   // of a burst, or with any slot when interrupts are switched off.
   always_comb begin
      clash          = wr_cmd || (active && (first || !intr_en));
      verdict.reject = rd_cmd && clash;
      verdict.accept = rd_cmd && active && !clash;
   end

endmodule

// File: rtl/wrint_dm_gen.sv
`timescale 1ns/1ps
module wrint_dm_gen #(
   parameter int BEATS = 2,
   parameter int LANES = 2
) (
   input  logic                   drive,
   input  logic                   mask_all,
   input  logic [BEATS-1:0]       vld,
   output logic [BEATS*LANES-1:0] dm
);

   generate
      for (genvar b = 0; b < BEATS; b++) begin : g_beat
         logic beat_mask;
         assign beat_mask = drive && (mask_all || !vld[b]);
         for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign dm[b*LANES + l] = beat_mask;
         end
      end
   endgenerate

endmodule

// File: rtl/wrint_mask_ctrl.sv
`timescale 1ns/1ps
module wrint_mask_ctrl
   import wrint_pkg::*;
#(
   parameter int LANES     = 2,
   parameter int BEATS     = 2,
   parameter int CAS_LAT   = 3,
   parameter int BL_CODE_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   intr_en,
   input  logic [BL_CODE_W-1:0]   bl_code,
   input  logic                   wr_cmd,
   input  logic                   rd_cmd,
   input  logic [BEATS-1:0]       wdat_vld,
   output logic [BEATS*LANES-1:0] dm_o,
   output logic                   oe_o,
   output logic                   rej_o
);

   localparam int MAX_SLOTS = 1 << ((1 << BL_CODE_W) - 2);
   localparam int SLOT_W    = $clog2(MAX_SLOTS + 1);
   localparam int HOLD      = CAS_LAT - 2;

   generate
      if (BEATS != 2) begin : g_bad_beats
         $error("wrint_mask_ctrl: two beats per clock required");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("wrint_mask_ctrl: LANES must be at least 1");
      end
      if (BL_CODE_W < 1 || BL_CODE_W > 4) begin : g_bad_code
         $error("wrint_mask_ctrl: BL_CODE_W out of range 1..4");
      end
      if (CAS_LAT < 2) begin : g_bad_lat
         $error("wrint_mask_ctrl: CAS_LAT must leave one idle clock");
      end
      if (HOLD > MAX_SLOTS) begin : g_bad_hold
         $error("wrint_mask_ctrl: hold window exceeds longest burst");
      end
   endgenerate

   logic        active;
   logic        first;
   logic        masked;
   rd_verdict_t verdict;

   wrint_burst_track #(
      .BL_CODE_W (BL_CODE_W),
      .SLOT_W    (SLOT_W),
      .HOLD      (HOLD)
   ) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (wr_cmd),
      .cut     (verdict.accept),
      .bl_code (bl_code),
      .active  (active),
      .first   (first),
      .masked  (masked)
   );

   wrint_rd_arbiter u_arb (
      .rd_cmd  (rd_cmd),
      .wr_cmd  (wr_cmd),
      .active  (active),
      .first   (first),
      .intr_en (intr_en),
      .verdict (verdict)
   );

   wrint_dm_gen #(
      .BEATS (BEATS),
      .LANES (LANES)
   ) u_dm (
      .drive    (active),
      .mask_all (masked || verdict.accept),
      .vld      (wdat_vld),
      .dm       (dm_o)
   );

   assign oe_o  = active;
   assign rej_o = verdict.reject;

endmodule

// File: rtl/wrint_mask_ctrl_chk.sv
`timescale 1ns/1ps
module wrint_mask_ctrl_chk #(
   parameter int LANES   = 2,
   parameter int BEATS   = 2,
   parameter int CAS_LAT = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   wr_cmd,
   input logic                   rd_cmd,
   input logic [BEATS-1:0]       wdat_vld,
   input logic [BEATS*LANES-1:0] dm_o,
   input logic                   oe_o,
   input logic                   rej_o
);

   logic       took_read;
   logic [7:0] since_cut;

   assign took_read = rd_cmd && oe_o && !rej_o;

   // Cycles since the last accepted interrupt; cleared by a new write.
   always_ff @(posedge clk) begin
      if (!rst_n)                                   since_cut <= '0;
      else if (wr_cmd)                              since_cut <= '0;
      else if (took_read)                           since_cut <= 8'd1;
      else if (since_cut != '0 && since_cut < 8'(CAS_LAT - 1))
                                                    since_cut <= since_cut + 8'd1;
      else                                          since_cut <= '0;
   end

   // R9
   dm_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_o |-> (dm_o == '0));

   // R2
   too_soon_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cmd && oe_o && $past(wr_cmd)) |-> rej_o);

   // R3
   reject_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rej_o |-> rd_cmd);

   // R4
   mask_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      took_read |-> (&dm_o));

   // R4
   mask_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (took_read && !wr_cmd) |=> (oe_o -> (&dm_o)));

   // R6
   release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_cut == 8'(CAS_LAT - 1)) |-> !oe_o);

   // R10
   same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cmd && wr_cmd) |-> rej_o);

   // R8
   beat0_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_o && !wdat_vld[0]) |-> (&dm_o[LANES-1:0]));

endmodule

bind wrint_mask_ctrl wrint_mask_ctrl_chk #(
   .LANES   (LANES),
   .BEATS   (BEATS),
   .CAS_LAT (CAS_LAT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_cmd   (wr_cmd),
   .rd_cmd   (rd_cmd),
   .wdat_vld (wdat_vld),
   .dm_o     (dm_o),
   .oe_o     (oe_o),
   .rej_o    (rej_o)
);

// File: tb/wrint_mask_ctrl_bench.sv
`timescale 1ns/1ps
module wrint_mask_ctrl_bench;

   localparam int LANES     = 2;
   localparam int BEATS     = 2;
   localparam int CAS_LAT   = 3;
   localparam int BL_CODE_W = 2;
   localparam int DM_W      = BEATS * LANES;
   localparam int NCYC      = 10;

   // Write in cycle 0, read in cycle gap (0 = no read). Bit c of each
   // pattern is the expectation for cycle c (dm bit = all mask bits set).
   typedef struct packed {
      logic [1:0]      code;
      logic [3:0]      gap;
      logic            en;
      logic [NCYC-1:0] oe;
      logic [NCYC-1:0] dm;
      logic [NCYC-1:0] rej;
   } vec_t;

   localparam int NVEC = 11;
   localparam vec_t VECS [NVEC] = '{
      '{2'd3, 4'd0, 1'b1, 10'b0000011110, 10'b0000000000, 10'b0000000000},
      '{2'd3, 4'd1, 1'b1, 10'b0000011110, 10'b0000000000, 10'b0000000010},
      '{2'd3, 4'd2, 1'b1, 10'b0000001110, 10'b0000001100, 10'b0000000000},
      '{2'd3, 4'd3, 1'b1, 10'b0000011110, 10'b0000011000, 10'b0000000000},
      '{2'd3, 4'd4, 1'b1, 10'b0000011110, 10'b0000010000, 10'b0000000000},
      '{2'd3, 4'd2, 1'b0, 10'b0000011110, 10'b0000000000, 10'b0000000100},
      '{2'd2, 4'd2, 1'b1, 10'b0000000110, 10'b0000000100, 10'b0000000000},
      '{2'd1, 4'd2, 1'b1, 10'b0000000010, 10'b0000000000, 10'b0000000000},
      '{2'd1, 4'd1, 1'b1, 10'b0000000010, 10'b0000000000, 10'b0000000010},
      '{2'd0, 4'd0, 1'b1, 10'b0000000000, 10'b0000000000, 10'b0000000000},
      '{2'd2, 4'd3, 1'b0, 10'b0000000110, 10'b0000000000, 10'b0000000000}
   };

   logic                 clk;
   logic                 rst_n;
   logic                 intr_en;
   logic [BL_CODE_W-1:0] bl_code;
   logic                 wr_cmd;
   logic                 rd_cmd;
   logic [BEATS-1:0]     wdat_vld;
   logic [DM_W-1:0]      dm_o;
   logic                 oe_o;
   logic                 rej_o;

   int checks = 0;
   int fails  = 0;

   wrint_mask_ctrl #(
      .LANES     (LANES),
      .BEATS     (BEATS),
      .CAS_LAT   (CAS_LAT),
      .BL_CODE_W (BL_CODE_W)
   ) u_wrint_mask_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .intr_en  (intr_en),
      .bl_code  (bl_code),
      .wr_cmd   (wr_cmd),
      .rd_cmd   (rd_cmd),
      .wdat_vld (wdat_vld),
      .dm_o     (dm_o),
      .oe_o     (oe_o),
      .rej_o    (rej_o)
   );

   initial clk = 1'b0;
   always #2 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // Drive one cycle's inputs after the falling edge, then let outputs settle.
   task automatic step(input logic w, input logic r, input logic [BEATS-1:0] v);
      @(negedge clk);
      wr_cmd   = w;
      rd_cmd   = r;
      wdat_vld = v;
      #1;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      summary();
   end

   initial begin
      rst_n    = 1'b0;
      intr_en  = 1'b1;
      bl_code  = '0;
      wr_cmd   = 1'b0;
      rd_cmd   = 1'b0;
      wdat_vld = '1;
      repeat (3) @(negedge clk);
      #1;
      // R11 reset state
      chk("R11 oe in reset",  32'(oe_o),  32'd0);
      chk("R11 dm in reset",  32'(dm_o),  32'd0);
      chk("R11 rej in reset", 32'(rej_o), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // Table walk: R1 R2 R3 R4 R5 R6 R7 R9
      for (int i = 0; i < NVEC; i++) begin
         logic [NCYC-1:0] oe_seen;
         logic [NCYC-1:0] dm_seen;
         logic [NCYC-1:0] rej_seen;
         bit              split_dm;
         split_dm = 1'b0;
         for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            bl_code = VECS[i].code;
            intr_en = VECS[i].en;
            wr_cmd  = (c == 0);
            rd_cmd  = (VECS[i].gap != 0) && (c == int'(VECS[i].gap));
            #1;
            oe_seen[c]  = oe_o;
            dm_seen[c]  = (dm_o == {DM_W{1'b1}});
            rej_seen[c] = rej_o;
            if (dm_o != '0 && dm_o != {DM_W{1'b1}}) split_dm = 1'b1;
         end
         @(negedge clk);
         wr_cmd = 1'b0;
         rd_cmd = 1'b0;
         chk($sformatf("R1 R6 oe pattern vec %0d", i), 32'(oe_seen), 32'(VECS[i].oe));
         chk($sformatf("R4 R5 dm pattern vec %0d", i), 32'(dm_seen), 32'(VECS[i].dm));
         chk($sformatf("R2 R3 R7 rej pattern vec %0d", i), 32'(rej_seen), 32'(VECS[i].rej));
         chk($sformatf("R9 lanes equal vec %0d", i), 32'(split_dm), 32'd0);
      end

      // R8: invalid beats masked per beat, both lanes
      intr_en = 1'b1;
      bl_code = 2'd2;
      step(1'b1, 1'b0, 2'b11);
      step(1'b0, 1'b0, 2'b01);
      chk("R8 beat1 invalid", 32'(dm_o), 32'h0C);
      step(1'b0, 1'b0, 2'b10);
      chk("R8 beat0 invalid", 32'(dm_o), 32'h03);
      step(1'b0, 1'b0, 2'b00);
      chk("R9 idle dm with invalid beats", 32'(dm_o), 32'h0);
      step(1'b0, 1'b0, 2'b11);

      // R10: read and write in the same cycle
      step(1'b1, 1'b1, 2'b11);
      chk("R10 same-cycle reject", 32'(rej_o), 32'd1);
      step(1'b0, 1'b0, 2'b11);
      chk("R10 write slot 1 oe", 32'(oe_o), 32'd1);
      chk("R10 write slot 1 dm", 32'(dm_o), 32'h0);
      step(1'b0, 1'b0, 2'b11);
      chk("R10 write slot 2 oe", 32'(oe_o), 32'd1);
      step(1'b0, 1'b0, 2'b11);
      chk("R10 write done", 32'(oe_o), 32'd0);

      // R7: lone read with the bus idle
      step(1'b0, 1'b1, 2'b11);
      chk("R7 lone read rej", 32'(rej_o), 32'd0);
      chk("R7 lone read oe", 32'(oe_o), 32'd0);
      step(1'b0, 1'b0, 2'b11);
      chk("R7 after lone read dm", 32'(dm_o), 32'h0);

      repeat (2) @(negedge clk);
      summary();
   end

endmodule